// File: doc/BRIEF.md
# DMA Block Countdown Interrupt Generator

This block keeps count of how many bytes of a playback buffer are still to be moved before the sound card must interrupt the host. When a transfer starts, it captures the block size in bytes, the auto-init choice and a ring length. From then on it accepts byte-count requests from the DMA engine while its DMA request is raised. It reports how many bytes each request actually moved and keeps a position inside the ring that wraps back to zero.

When the countdown reaches zero or goes below it, the block ORs the interrupt-source bits of its IRQ configuration register into a sticky status register. It pulses an IRQ request unless interrupts are suppressed, and it adds the block size back to the countdown, so any overshoot carries into the next block. In single-cycle mode the last request is clipped to the bytes that remain, and the DMA request drops at the end of the block. A read strobe on the 16-bit acknowledge port clears that source's status bit. The sample data path and the audio output are outside this block.

Top module: `dbc_block_irq`

## Requirements
- R1: After reset, remain_o=0, pos_o=0, status_o=0x00, irq_o=0, dreq_o=0, take_vld_o=0 and taken_o=0. irq_cfg_o resets to the code of parameter IRQ_LINE (default 5, code 0x02). dma_cfg_o resets to 0x20 | (DMA_CHAN<<1) (default channel 1, value 0x22).
- R2: A cycle with start_i high loads remain_o with buf_size_i and pos_o with 0, raises dreq_o and latches auto_init_i. Any transfer request in that same cycle is ignored.
- R3: A request is accepted when xfer_req_i=1, dreq_o=1, speaker_on_i=1, chunk_i is nonzero and remain_o is not negative. The bytes taken equal chunk_i, except in single-cycle mode (auto flag 0) with remain_o <= chunk_i, where they equal remain_o. In the next cycle taken_o shows that count with take_vld_o=1, and remain_o is lower by that count. In any other cycle taken_o=0 and take_vld_o=0.
- R4: pos_o advances by the bytes taken. When the sum reaches or passes ring_len_i, ring_len_i is subtracted. This assumes a chunk no larger than ring_len_i.
- R5: When an accepted request leaves the countdown at 0 or below (an expiry), status_o is ORed with the irq_cfg_o value of that cycle, and buf_size is added back to the countdown.
- R6: An expiry produces irq_o=1 for exactly one cycle, in the cycle after the request, unless irq_suppress_i was 1 in the request cycle.
- R7: An expiry in single-cycle mode clears dreq_o. In auto-init mode dreq_o stays high.
- R8: ack16_i=1 clears status bit 1 and no other bit. While ack16_i=1, ack_rdata_o=0xFF; otherwise it is 0x00. If an acknowledge and an expiry fall in the same cycle, the bits set by the expiry win.
- R9: While speaker_on_i=0, chunk_i=0 or dreq_o=0, a request has no effect: remain_o, pos_o and status_o hold.
- R10: cfg_we_i=1 writes cfg_wdata_i to irq_cfg_o when cfg_sel_i=0 and to dma_cfg_o when cfg_sel_i=1. IRQ lines 2, 5, 7 and 10 encode as 0x01, 0x02, 0x04 and 0x08.
- R11: A qualifying request that finds remain_o negative moves no bytes (take_vld_o=0) and only adds buf_size to the countdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin a transfer block |
| buf_size_i | input | SW | Block size in bytes, captured at start |
| auto_init_i | input | 1 | Auto-init mode, captured at start |
| speaker_on_i | input | 1 | Output enabled; requests are ignored while low |
| irq_suppress_i | input | 1 | Suppress the IRQ pulse |
| xfer_req_i | input | 1 | DMA engine request this cycle |
| chunk_i | input | SW | Proposed bytes for this request |
| ring_len_i | input | SW | Ring length for position wrap |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 1 | 0 selects IRQ configuration, 1 selects DMA configuration |
| cfg_wdata_i | input | 8 | Configuration write data |
| ack16_i | input | 1 | 16-bit acknowledge read strobe |
| remain_o | output | SW+2 | Signed bytes left before expiry |
| pos_o | output | SW | Position in the ring |
| taken_o | output | SW | Bytes moved by the previous request |
| take_vld_o | output | 1 | taken_o is valid |
| status_o | output | 8 | Sticky interrupt status |
| irq_o | output | 1 | One-cycle IRQ request |
| dreq_o | output | 1 | DMA request held |
| irq_cfg_o | output | 8 | IRQ configuration register |
| dma_cfg_o | output | 8 | DMA configuration register |
| ack_rdata_o | output | 8 | Acknowledge read data |

## Verification
The assertions check local relations on every cycle. An IRQ pulse must follow an expiry, and the status register must then hold the configured bits. Status bits may drop only through the acknowledge. dreq_o may fall only on an expiry. Bytes taken never exceed the offered chunk, the position stays inside the ring, the state holds while output is disabled, and a start loads its values. Only the bench's reference model can show the exact arithmetic: single-cycle clipping, the carry of overshoot across a reload, the reload-only path for a negative countdown, and expiry and acknowledge in the same cycle.

// File: rtl/dbc_pkg.sv
// Shared constants and reset-value helpers for the block countdown interrupt generator.
package dbc_pkg;
    localparam int ACK16_BIT = 1;

    // Map an IRQ line number to its one-hot source code; unknown lines fall back to line 5.
    function automatic logic [7:0] irq_line_code(input int line);
        case (line)
            2:       irq_line_code = 8'h01;
            5:       irq_line_code = 8'h02;
            7:       irq_line_code = 8'h04;
            10:      irq_line_code = 8'h08;
            default: irq_line_code = 8'h02;
        endcase
    endfunction

    // Reset value of the DMA configuration register for a low channel number.
    function automatic logic [7:0] dma_cfg_reset(input int chan);
        logic [7:0] c;
        c = 8'(chan & 3);
        dma_cfg_reset = 8'h20 | (c << 1);
    endfunction
endpackage

// File: rtl/dbc_cfg_regs.sv
// Configuration registers: IRQ source code and DMA channel setup.
// Assumes one write port; a write takes effect on the next cycle.
module dbc_cfg_regs #(
    parameter int IRQ_LINE = 5,
    parameter int DMA_CHAN = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_we_i,
    input  logic       cfg_sel_i,
    input  logic [7:0] cfg_wdata_i,
    output logic [7:0] irq_cfg_o,
    output logic [7:0] dma_cfg_o
);
    import dbc_pkg::*;

    localparam logic [7:0] IRQ_RST = irq_line_code(IRQ_LINE);
    localparam logic [7:0] DMA_RST = dma_cfg_reset(DMA_CHAN);

    // Register write and reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_cfg_o <= IRQ_RST;
            dma_cfg_o <= DMA_RST;
        end else if (cfg_we_i) begin
            if (cfg_sel_i) dma_cfg_o <= cfg_wdata_i;
            else           irq_cfg_o <= cfg_wdata_i;
        end
    end
endmodule

// File: rtl/dbc_countdown.sv
// Signed byte countdown, ring position and per-request byte count.
// Assumes chunk_i <= ring_len_i and ring_len_i > 0 while requests flow.
module dbc_countdown #(
    parameter int SW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [SW-1:0]        buf_size_i,
    input  logic                 auto_init_i,
    input  logic                 speaker_on_i,
    input  logic                 xfer_req_i,
    input  logic [SW-1:0]        chunk_i,
    input  logic [SW-1:0]        ring_len_i,
    input  logic                 dreq_i,
    output logic signed [SW+1:0] remain_o,
    output logic [SW-1:0]        pos_o,
    output logic [SW-1:0]        taken_o,
    output logic                 take_vld_o,
    output logic                 expire_o,
    output logic                 auto_o
);
    localparam int CW = SW + 2;

    logic [SW-1:0]        size_q;
    logic signed [CW-1:0] size_s, chunk_s, dec_s, cnt_n;
    logic [SW-1:0]        take;
    logic [SW:0]          psum, pos_n;
    logic                 accept, reload_only, do_take;

    assign size_s  = $signed({2'b00, size_q});
    assign chunk_s = $signed({2'b00, chunk_i});

    // Qualify a request and pick the reload-only or transfer path.
    always_comb begin
        accept      = xfer_req_i && dreq_i && speaker_on_i && (chunk_i != '0) && !start_i;
        reload_only = accept && remain_o[CW-1];
        do_take     = accept && !remain_o[CW-1];
    end

    // Bytes taken: clipped to the remainder in single-cycle mode.
    always_comb begin
        if (!auto_o && (remain_o <= chunk_s)) take = remain_o[SW-1:0];
        else                                   take = chunk_i;
    end

    // Countdown after the take, and expiry with reload.
    always_comb begin
        dec_s    = remain_o - $signed({2'b00, take});
        expire_o = do_take && (dec_s <= 0);
        cnt_n    = remain_o;
        if (reload_only)   cnt_n = remain_o + size_s;
        else if (expire_o) cnt_n = dec_s + size_s;
        else if (do_take)  cnt_n = dec_s;
    end

    // Ring position advance with wrap.
    always_comb begin
        psum = {1'b0, pos_o} + {1'b0, take};
        if (psum >= {1'b0, ring_len_i}) pos_n = psum - {1'b0, ring_len_i};
        else                            pos_n = psum;
    end

    // State update: start loads, accepted requests advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain_o   <= '0;
            pos_o      <= '0;
            size_q     <= '0;
            auto_o     <= 1'b0;
            taken_o    <= '0;
            take_vld_o <= 1'b0;
        end else begin
            take_vld_o <= do_take;
            taken_o    <= do_take ? take : '0;
            if (start_i) begin
                remain_o <= $signed({2'b00, buf_size_i});
                size_q   <= buf_size_i;
                pos_o    <= '0;
                auto_o   <= auto_init_i;
            end else begin
                remain_o <= cnt_n;
                if (do_take) pos_o <= pos_n[SW-1:0];
            end
        end
    end
endmodule

// File: rtl/dbc_status.sv
// Sticky interrupt status, IRQ pulse and DMA request hold/release.
// Assumes expire_i is a single-cycle strobe from the countdown.
module dbc_status (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       expire_i,
    input  logic       auto_i,
    input  logic       irq_suppress_i,
    input  logic       ack16_i,
    input  logic [7:0] irq_cfg_i,
    output logic [7:0] status_o,
    output logic       irq_o,
    output logic       dreq_o
);
    import dbc_pkg::*;

    logic [7:0] clr_mask, set_mask;

    // Acknowledge clears its own bit; expiry sets the configured sources.
    always_comb begin
        clr_mask            = '0;
        clr_mask[ACK16_BIT] = ack16_i;
        set_mask            = expire_i ? irq_cfg_i : '0;
    end

    // Status, IRQ pulse and DMA request registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_o <= '0;
            irq_o    <= 1'b0;
            dreq_o   <= 1'b0;
        end else begin
            status_o <= (status_o & ~clr_mask) | set_mask;
            irq_o    <= expire_i && !irq_suppress_i;
            if (start_i)                  dreq_o <= 1'b1;
            else if (expire_i && !auto_i) dreq_o <= 1'b0;
        end
    end
endmodule

// File: rtl/dbc_block_irq.sv
// Top: DMA block countdown interrupt generator.
// Assumes the DMA engine offers at most one request per cycle.
module dbc_block_irq #(
    parameter int SW       = 16,
    parameter int IRQ_LINE = 5,
    parameter int DMA_CHAN = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [SW-1:0]        buf_size_i,
    input  logic                 auto_init_i,
    input  logic                 speaker_on_i,
    input  logic                 irq_suppress_i,
    input  logic                 xfer_req_i,
    input  logic [SW-1:0]        chunk_i,
    input  logic [SW-1:0]        ring_len_i,
    input  logic                 cfg_we_i,
    input  logic                 cfg_sel_i,
    input  logic [7:0]           cfg_wdata_i,
    input  logic                 ack16_i,
    output logic signed [SW+1:0] remain_o,
    output logic [SW-1:0]        pos_o,
    output logic [SW-1:0]        taken_o,
    output logic                 take_vld_o,
    output logic [7:0]           status_o,
    output logic                 irq_o,
    output logic                 dreq_o,
    output logic [7:0]           irq_cfg_o,
    output logic [7:0]           dma_cfg_o,
    output logic [7:0]           ack_rdata_o
);
    logic expire_w, auto_w;

    // Acknowledge port read data.
    always_comb ack_rdata_o = ack16_i ? 8'hFF : 8'h00;

    dbc_cfg_regs #(.IRQ_LINE(IRQ_LINE), .DMA_CHAN(DMA_CHAN)) cfg_i (
        .clk(clk), .rst_n(rst_n), .cfg_we_i(cfg_we_i), .cfg_sel_i(cfg_sel_i),
        .cfg_wdata_i(cfg_wdata_i), .irq_cfg_o(irq_cfg_o), .dma_cfg_o(dma_cfg_o)
    );

    dbc_countdown #(.SW(SW)) cnt_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .buf_size_i(buf_size_i),
        .auto_init_i(auto_init_i), .speaker_on_i(speaker_on_i), .xfer_req_i(xfer_req_i),
        .chunk_i(chunk_i), .ring_len_i(ring_len_i), .dreq_i(dreq_o),
        .remain_o(remain_o), .pos_o(pos_o), .taken_o(taken_o), .take_vld_o(take_vld_o),
        .expire_o(expire_w), .auto_o(auto_w)
    );

    dbc_status stat_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .expire_i(expire_w), .auto_i(auto_w),
        .irq_suppress_i(irq_suppress_i), .ack16_i(ack16_i), .irq_cfg_i(irq_cfg_o),
        .status_o(status_o), .irq_o(irq_o), .dreq_o(dreq_o)
    );
endmodule

// File: rtl/dbc_block_irq_chk.sv
// Checker for dbc_block_irq: temporal relations between ports and the expiry strobe.
module dbc_block_irq_chk #(
    parameter int SW = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 start_i,
    input logic [SW-1:0]        buf_size_i,
    input logic                 speaker_on_i,
    input logic                 irq_suppress_i,
    input logic [SW-1:0]        chunk_i,
    input logic [SW-1:0]        ring_len_i,
    input logic                 ack16_i,
    input logic                 expire_w,
    input logic signed [SW+1:0] remain_o,
    input logic [SW-1:0]        pos_o,
    input logic [SW-1:0]        taken_o,
    input logic                 take_vld_o,
    input logic [7:0]           status_o,
    input logic                 irq_o,
    input logic                 dreq_o,
    input logic [7:0]           irq_cfg_o,
    input logic [7:0]           ack_rdata_o
);
    assert_start_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(start_i) |-> (pos_o == '0) && dreq_o && (remain_o == $signed({2'b00, $past(buf_size_i)})));

    assert_take_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
        take_vld_o |-> (taken_o <= $past(chunk_i)));

    assert_pos_in_ring_R4: assert property (@(posedge clk) disable iff (!rst_n)
        take_vld_o |-> (pos_o < $past(ring_len_i)));

    assert_status_has_cfg_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ((status_o & $past(irq_cfg_o)) == $past(irq_cfg_o)));

    assert_irq_after_expiry_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ($past(expire_w) && !$past(irq_suppress_i)));

    assert_dreq_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dreq_o) |-> $past(expire_w));

    assert_sticky_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((~status_o & $past(status_o) & 8'hFD) == 8'h00));

    assert_ack_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(status_o[1]) && !status_o[1]) |-> $past(ack16_i));

    assert_ack_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ack16_i |-> (ack_rdata_o == 8'hFF));

    assert_hold_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!speaker_on_i) && $past(!start_i)) |-> ($stable(remain_o) && $stable(pos_o)));
endmodule

bind dbc_block_irq dbc_block_irq_chk #(.SW(SW)) chk_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .buf_size_i(buf_size_i),
    .speaker_on_i(speaker_on_i), .irq_suppress_i(irq_suppress_i), .chunk_i(chunk_i),
    .ring_len_i(ring_len_i), .ack16_i(ack16_i), .expire_w(expire_w),
    .remain_o(remain_o), .pos_o(pos_o), .taken_o(taken_o), .take_vld_o(take_vld_o),
    .status_o(status_o), .irq_o(irq_o), .dreq_o(dreq_o), .irq_cfg_o(irq_cfg_o),
    .ack_rdata_o(ack_rdata_o)
);

// File: tb/dbc_block_irq_tb.sv
module dbc_block_irq_tb_top;
    localparam int SW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 0, auto_init_i = 0, speaker_on_i = 0, irq_suppress_i = 0;
    logic xfer_req_i = 0, cfg_we_i = 0, cfg_sel_i = 0, ack16_i = 0;
    logic [SW-1:0] buf_size_i = '0, chunk_i = '0, ring_len_i = 16'd16;
    logic [7:0] cfg_wdata_i = '0;
    logic signed [SW+1:0] remain_o;
    logic [SW-1:0] pos_o, taken_o;
    logic take_vld_o, irq_o, dreq_o;
    logic [7:0] status_o, irq_cfg_o, dma_cfg_o, ack_rdata_o;

    always #5 clk = ~clk;

    dbc_block_irq #(.SW(SW)) dut_i (.*);

    int checks = 0, fails = 0, cycles = 0;

    // Reference model state
    int m_cnt = 0, m_pos = 0, m_size = 0, m_taken = 0;
    bit m_auto = 0, m_dreq = 0, m_irq = 0, m_tv = 0;
    logic [7:0] m_stat = 0, m_icfg = 8'h02, m_dcfg = 8'h22;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    // Behavioural reference model, advanced on every clock.
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_cnt = 0; m_pos = 0; m_size = 0; m_auto = 0; m_dreq = 0;
            m_stat = 0; m_irq = 0; m_tv = 0; m_taken = 0; m_icfg = 8'h02; m_dcfg = 8'h22;
        end else begin
            bit acc, exp;
            int tk;
            acc = xfer_req_i && m_dreq && speaker_on_i && (chunk_i != 0) && !start_i;
            exp = 0; tk = 0; m_tv = 0;
            if (start_i) begin
                m_cnt = int'(buf_size_i); m_size = int'(buf_size_i); m_pos = 0;
                m_auto = auto_init_i; m_dreq = 1;
            end else if (acc) begin
                if (m_cnt < 0) m_cnt += m_size;
                else begin
                    tk = (!m_auto && m_cnt <= int'(chunk_i)) ? m_cnt : int'(chunk_i);
                    m_tv = 1;
                    m_cnt -= tk;
                    m_pos += tk;
                    if (m_pos >= int'(ring_len_i)) m_pos -= int'(ring_len_i);
                    if (m_cnt <= 0) begin exp = 1; m_cnt += m_size; end
                end
            end
            m_taken = tk;
            if (ack16_i) m_stat[1] = 1'b0;
            if (exp) m_stat |= m_icfg;
            m_irq = exp && !irq_suppress_i;
            if (exp && !m_auto) m_dreq = 0;
            if (cfg_we_i) begin
                if (cfg_sel_i) m_dcfg = cfg_wdata_i; else m_icfg = cfg_wdata_i;
            end
        end
    end

    // Compare away from the edge, every cycle after reset.
    always @(posedge clk) begin
        #2;
        if (rst_n) begin
            chk(int'(remain_o) == m_cnt, "R3 remain", remain_o, m_cnt);
            chk(int'(pos_o) == m_pos, "R4 pos", pos_o, m_pos);
            chk(take_vld_o == m_tv && int'(taken_o) == m_taken, "R3 taken", taken_o, m_taken);
            chk(status_o == m_stat, "R5 status", status_o, m_stat);
            chk(irq_o == m_irq, "R6 irq", irq_o, m_irq);
            chk(dreq_o == m_dreq, "R7 dreq", dreq_o, m_dreq);
            chk(irq_cfg_o == m_icfg && dma_cfg_o == m_dcfg, "R10 cfg", {irq_cfg_o, dma_cfg_o}, {m_icfg, m_dcfg});
            chk(ack_rdata_o == (ack16_i ? 8'hFF : 8'h00), "R8 ack data", ack_rdata_o, ack16_i ? 255 : 0);
        end
    end

    task automatic go_start(input int size, input bit aut, input int ring);
        @(negedge clk);
        start_i = 1; buf_size_i = SW'(size); auto_init_i = aut; ring_len_i = SW'(ring);
        xfer_req_i = 0;
        @(negedge clk);
        start_i = 0;
    endtask

    task automatic req(input int ch, input int n);
        for (int i = 0; i < n; i++) begin
            if (i == 0) ; else @(negedge clk);
            xfer_req_i = 1; chunk_i = SW'(ch);
        end
        @(negedge clk);
        xfer_req_i = 0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(remain_o == 0 && pos_o == 0 && status_o == 0 && !irq_o && !dreq_o && !take_vld_o && taken_o == 0,
            "R1 reset outputs", status_o, 0);
        chk(irq_cfg_o == 8'h02, "R1 irq cfg reset", irq_cfg_o, 8'h02);
        chk(dma_cfg_o == 8'h22, "R1 dma cfg reset", dma_cfg_o, 8'h22);

        speaker_on_i = 1;
        // R9 request before any start: dreq low, ignored
        req(4, 2);
        chk(remain_o == 0 && pos_o == 0, "R9 ignored without dreq", remain_o, 0);

        // R2/R3/R7 single-cycle block 10 in chunks of 4: 4,4,2 then drop
        go_start(10, 0, 16);
        chk(remain_o == 10 && dreq_o, "R2 start load", remain_o, 10);
        req(4, 4);
        @(negedge clk);
        chk(!dreq_o && pos_o == 10 && status_o == 8'h02, "R7 single stop", pos_o, 10);

        // R9 speaker off / zero chunk hold
        go_start(20, 1, 16);
        @(negedge clk); speaker_on_i = 0;
        req(5, 2);
        speaker_on_i = 1;
        req(0, 2);
        chk(remain_o == 20, "R9 hold", remain_o, 20);

        // R5/R4 auto-init with overshoot carried and ring wrap
        go_start(6, 1, 8);
        req(4, 4);
        @(negedge clk);
        chk(dreq_o, "R7 auto keeps dreq", dreq_o, 1);

        // R8 acknowledge
        @(negedge clk); ack16_i = 1;
        @(negedge clk); ack16_i = 0;
        @(negedge clk);
        chk(status_o[1] == 1'b0, "R8 ack clear", status_o, 0);

        // R6 suppressed interrupt still sets status
        irq_suppress_i = 1;
        go_start(3, 1, 8);
        req(3, 1);
        irq_suppress_i = 0;
        @(negedge clk);
        chk(status_o == 8'h02, "R6 suppressed status", status_o, 2);

        // R11 negative remainder reloads only
        go_start(4, 1, 32);
        req(20, 1);
        req(1, 3);
        @(negedge clk);

        // R2 start wins over same-cycle request
        @(negedge clk);
        start_i = 1; buf_size_i = 16'd7; auto_init_i = 0; xfer_req_i = 1; chunk_i = 16'd3;
        @(negedge clk);
        start_i = 0; xfer_req_i = 0;
        chk(remain_o == 7 && !take_vld_o, "R2 start priority", remain_o, 7);

        // R10 config writes; R8 ack and expiry together
        @(negedge clk); cfg_we_i = 1; cfg_sel_i = 0; cfg_wdata_i = 8'h08;
        @(negedge clk); cfg_sel_i = 1; cfg_wdata_i = 8'h2A;
        @(negedge clk); cfg_we_i = 0;
        chk(irq_cfg_o == 8'h08 && dma_cfg_o == 8'h2A, "R10 write", irq_cfg_o, 8);
        go_start(2, 0, 16);
        ack16_i = 1;
        req(2, 1);
        ack16_i = 0;
        @(negedge clk);
        chk(status_o == 8'h08, "R8 set wins with ack", status_o, 8);

        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog
    initial begin
        #100000;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule